// File: doc/BRIEF.md
# Chained DMA Descriptor Loader

This block is a single DMA channel that moves words from a serial peripheral's receive stream into internal memory. It takes no per-transfer settings from the processor. Each transfer is described by a four-word block in internal memory, and the channel fetches that block into its working registers. Each block names the next one, so a whole list of buffers is filled with no software involvement.

Software writes one register: the address of the first descriptor and an enable bit. From then on the channel alternates between two phases. In the load phase it reads the four descriptor words. In the transfer phase it accepts peripheral words and writes each one to memory, stepping the address by a signed stride after every word. A next-descriptor pointer of zero ends the chain, and a one-cycle completion pulse marks the end. A pointer that leads back to an earlier descriptor makes a ring, and the ring runs until the enable bit is cleared. The active status is high only while data can move. It reads low during every descriptor load, so software cannot tell from it that a chain has finished. The completion pulse is the signal to use for that.

Top module: `dmac_chain_ldr`

## Requirements
- R1: With the channel idle, a configuration write with enable set and a nonzero pointer P causes memory reads of P, P+1, P+2 and P+3 on four consecutive cycles, starting in the cycle after the write. Read data returns one cycle after each read.
- R2: Descriptor word layout. Offset 0 is the next-descriptor pointer. Offset 1 is the word count. Offset 2 is the signed address stride (two's complement). Offset 3 is the first buffer address.
- R3: During a transfer, each accepted peripheral word (per_valid and per_ready both high) is written to memory at the current address. The address then advances by the stride, modulo the address width. Exactly the count number of words is accepted.
- R4: After the last word of a descriptor, a nonzero next pointer makes the channel load that descriptor and continue on its own.
- R5: A next pointer of zero, reached after the last word or after a skipped descriptor, returns the channel to idle and raises chain_done for exactly one cycle.
- R6: chan_active is high only while words can be accepted. It is low during descriptor loads. per_ready is never high while chan_active is low.
- R7: A descriptor with a count of zero moves no data and writes no memory. The channel goes straight on to its next pointer.
- R8: A configuration write with enable set and a zero pointer performs no memory access.
- R9: Clearing enable during a transfer drops per_ready at once. The channel then goes idle with no further memory access and no chain_done pulse.
- R10: A chain whose pointers loop back keeps transferring across repeated passes until enable is cleared.
- R11: During reset, the channel is idle: chan_active, per_ready, mem_en and chain_done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_en | input | 1 | Channel enable value written |
| cfg_link | input | AW | First descriptor address (used only from idle) |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after the read |
| per_valid | input | 1 | Peripheral word available |
| per_data | input | DW | Peripheral word |
| per_ready | output | 1 | Channel accepts the peripheral word |
| chan_active | output | 1 | Transfer phase in progress |
| chain_done | output | 1 | One-cycle pulse at the natural end of a chain |

## Verification
The assertions assume a memory that always answers a read on the following cycle, with no wait states. They also assume that descriptors never sit at address zero, because zero is the end marker. The bench's memory model serves every read after exactly one cycle. Descriptors are placed in the top quarter of the address space, and buffers are kept in the lower region, so descriptor words are never overwritten. Peripheral valid is random, but data is held until it is accepted. Configuration writes that start a chain are issued only while the channel is idle.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   localparam int unsigned DESC_WORDS = 4;
   localparam int unsigned SLOT_W     = $clog2(DESC_WORDS);

   typedef enum logic [1:0] {
      CH_IDLE = 2'd0,
      CH_LOAD = 2'd1,
      CH_XFER = 2'd2
   } ch_state_t;

   // Slot order is behaviour: it fixes the word offsets within a descriptor.
   typedef enum logic [SLOT_W-1:0] {
      D_LINK   = 2'd0,
      D_COUNT  = 2'd1,
      D_STRIDE = 2'd2,
      D_BASE   = 2'd3
   } desc_slot_t;
endpackage

// File: rtl/dmac_desc_fetch.sv
module dmac_desc_fetch
   import dmac_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] base,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] rd_data,
   output logic          ld_valid,
   output desc_slot_t    ld_slot,
   output logic [DW-1:0] ld_data,
   output logic          ld_last
);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DESC_WORDS - 1);

   logic              issuing;
   logic [SLOT_W-1:0] iss_idx;
   logic [AW-1:0]     base_q;
   logic              pend;
   logic [SLOT_W-1:0] pend_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issuing  <= 1'b0;
         iss_idx  <= '0;
         base_q   <= '0;
         pend     <= 1'b0;
         pend_idx <= '0;
      end else begin
         pend     <= issuing;
         pend_idx <= iss_idx;
         if (start) begin
            issuing <= 1'b1;
            iss_idx <= '0;
            base_q  <= base;
         end else if (issuing) begin
            if (iss_idx == LAST_SLOT) issuing <= 1'b0;
            else iss_idx <= iss_idx + 1'b1;
         end
      end
   end

   assign rd_en    = issuing;
   assign rd_addr  = base_q + AW'(iss_idx);
   assign ld_valid = pend;
   assign ld_slot  = desc_slot_t'(pend_idx);
   assign ld_data  = rd_data;
   assign ld_last  = pend && (pend_idx == LAST_SLOT);

   // R1: descriptor words are read at consecutive addresses
   p_desc_seq_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && $past(rd_en) |-> rd_addr == $past(rd_addr) + AW'(1));

   // R4: a new load never begins while reads of the previous one are in flight
   p_no_restart_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !rd_en);

   // R1: each read is answered one cycle later in the matching slot
   p_read_lat_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> ld_valid);
endmodule

// File: rtl/dmac_xfer_dp.sv
module dmac_xfer_dp
   import dmac_pkg::*;
#(
   parameter int AW       = 8,
   parameter int DW       = 32,
   parameter int STRIDE_W = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_valid,
   input  desc_slot_t    ld_slot,
   input  logic [DW-1:0] ld_data,
   input  logic          step,
   output logic [AW-1:0] link_addr,
   output logic          link_nz,
   output logic          cnt_nz,
   output logic          last_word,
   output logic [AW-1:0] cur_addr
);
   logic [DW-1:0]         link_q;
   logic [DW-1:0]         cnt_q;
   logic [AW-1:0]         stride_q;
   logic [AW-1:0]         addr_q;
   logic [AW-1:0]         stride_in;
   logic [DESC_WORDS-1:0] hit;

   generate
      if (STRIDE_W >= AW) begin : g_stride_full
         assign stride_in = ld_data[AW-1:0];
      end else begin : g_stride_sext
         assign stride_in = {{(AW-STRIDE_W){ld_data[STRIDE_W-1]}},
                             ld_data[STRIDE_W-1:0]};
      end

      for (genvar g = 0; g < DESC_WORDS; g++) begin : g_slot
         assign hit[g] = ld_valid && (ld_slot == desc_slot_t'(SLOT_W'(g)));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_q   <= '0;
         cnt_q    <= '0;
         stride_q <= '0;
         addr_q   <= '0;
      end else begin
         if (hit[D_LINK])   link_q   <= ld_data;
         if (hit[D_STRIDE]) stride_q <= stride_in;
         if (hit[D_COUNT])  cnt_q    <= ld_data;
         else if (step)     cnt_q    <= cnt_q - 1'b1;
         if (hit[D_BASE])   addr_q   <= ld_data[AW-1:0];
         else if (step)     addr_q   <= addr_q + stride_q;
      end
   end

   assign link_addr = link_q[AW-1:0];
   assign link_nz   = |link_q;
   assign cnt_nz    = |cnt_q;
   assign last_word = (cnt_q == DW'(1));
   assign cur_addr  = addr_q;

   // R3: never accept a word with nothing left to move
   p_no_underflow_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      step |-> cnt_nz);

   // R3: each accepted word moves the address by the stride
   p_addr_step_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      step |=> cur_addr == $past(cur_addr) + $past(stride_q));
endmodule

// File: rtl/dmac_chain_ldr.sv
module dmac_chain_ldr
   import dmac_pkg::*;
#(
   parameter int AW       = 8,
   parameter int DW       = 32,
   parameter int STRIDE_W = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic          cfg_en,
   input  logic [AW-1:0] cfg_link,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          per_valid,
   input  logic [DW-1:0] per_data,
   output logic          per_ready,
   output logic          chan_active,
   output logic          chain_done
);
   generate
      if (AW < 2 || DW < AW) begin : g_bad_width
         $error("dmac_chain_ldr: need AW >= 2 and DW >= AW");
      end
      if (STRIDE_W < 1 || STRIDE_W > DW) begin : g_bad_stride
         $error("dmac_chain_ldr: STRIDE_W must lie in 1..DW");
      end
   endgenerate

   ch_state_t     state_q, state_d;
   logic          en_q;
   logic          done_q, done_d;
   logic          fetch_go;
   logic [AW-1:0] fetch_base;
   logic          rd_en;
   logic [AW-1:0] rd_addr;
   logic          ld_valid, ld_last;
   desc_slot_t    ld_slot;
   logic [DW-1:0] ld_data;
   logic [AW-1:0] link_addr, cur_addr;
   logic          link_nz, cnt_nz, last_word;
   logic          step;

   dmac_desc_fetch #(.AW(AW), .DW(DW)) u_fetch (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (fetch_go),
      .base    (fetch_base),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (mem_rdata),
      .ld_valid(ld_valid),
      .ld_slot (ld_slot),
      .ld_data (ld_data),
      .ld_last (ld_last)
   );

   dmac_xfer_dp #(.AW(AW), .DW(DW), .STRIDE_W(STRIDE_W)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_valid (ld_valid),
      .ld_slot  (ld_slot),
      .ld_data  (ld_data),
      .step     (step),
      .link_addr(link_addr),
      .link_nz  (link_nz),
      .cnt_nz   (cnt_nz),
      .last_word(last_word),
      .cur_addr (cur_addr)
   );

   assign per_ready   = (state_q == CH_XFER) && en_q;
   assign chan_active = (state_q == CH_XFER);
   assign step        = per_valid && per_ready;

   always_comb begin
      state_d    = state_q;
      fetch_go   = 1'b0;
      fetch_base = link_addr;
      done_d     = 1'b0;
      unique case (state_q)
         CH_IDLE: begin
            if (cfg_we && cfg_en && (cfg_link != '0)) begin
               state_d    = CH_LOAD;
               fetch_go   = 1'b1;
               fetch_base = cfg_link;
            end
         end
         CH_LOAD: begin
            if (ld_last) begin
               if (!en_q) begin
                  state_d = CH_IDLE;
               end else if (cnt_nz) begin
                  state_d = CH_XFER;
               end else if (link_nz) begin
                  fetch_go = 1'b1;
               end else begin
                  state_d = CH_IDLE;
                  done_d  = 1'b1;
               end
            end
         end
         CH_XFER: begin
            if (!en_q) begin
               state_d = CH_IDLE;
            end else if (step && last_word) begin
               if (link_nz) begin
                  state_d  = CH_LOAD;
                  fetch_go = 1'b1;
               end else begin
                  state_d = CH_IDLE;
                  done_d  = 1'b1;
               end
            end
         end
         default: state_d = CH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CH_IDLE;
         en_q    <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= done_d;
         if (cfg_we) en_q <= cfg_en;
      end
   end

   assign chain_done = done_q;
   assign mem_en     = rd_en || step;
   assign mem_we     = step;
   assign mem_addr   = rd_en ? rd_addr : cur_addr;
   assign mem_wdata  = per_data;

   // R6: descriptor reads happen only while the channel reports inactive
   p_load_inactive_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_en && !mem_we |-> !chan_active);

   // R3: memory writes only carry accepted peripheral words
   p_write_in_xfer_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> chan_active && per_valid);

   // R5: completion is a single-cycle pulse seen while idle
   p_done_pulse_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      chain_done |=> !chain_done);
   p_done_idle_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      chain_done |-> !chan_active && !mem_en);

   // R9: a disabled transfer leaves the transfer phase on the next cycle
   p_stop_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      chan_active && !per_ready |=> !chan_active && !mem_en);

   // R8: a zero first pointer starts no fetch
   p_zero_link_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_IDLE) && cfg_we && (cfg_link == '0) |=> !mem_en);
endmodule

// File: tb/sim_dmac_chain_ldr.sv
`timescale 1ns/1ps
module sim_dmac_chain_ldr;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam int MEMW = 1 << AW;
   localparam int BUF_TOP = 'hC0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0, cfg_en = 1'b0;
   logic [AW-1:0] cfg_link = '0;
   logic          mem_en, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata;
   logic          per_valid;
   logic [DW-1:0] per_data;
   logic          per_ready, chan_active, chain_done;

   logic [DW-1:0] mem [MEMW];
   logic [DW-1:0] expm [MEMW];
   logic          src_on = 1'b0;
   logic [DW-1:0] seq_next;
   int            errors = 0;
   int            checks = 0;

   always #2 clk = ~clk;

   dmac_chain_ldr #(.AW(AW), .DW(DW), .STRIDE_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
      .cfg_link(cfg_link), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .per_valid(per_valid), .per_data(per_data), .per_ready(per_ready),
      .chan_active(chan_active), .chain_done(chain_done)
   );

   // memory model: one-cycle read latency, plus bench preload port
   logic          pl_we = 1'b0;
   logic [AW-1:0] pl_addr = '0;
   logic [DW-1:0] pl_data = '0;
   always @(posedge clk) begin
      if (pl_we) mem[pl_addr] <= pl_data;
      else if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_en && !mem_we) mem_rdata <= mem[mem_addr];
   end

   // peripheral source: data held until accepted
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) seq_next <= 32'h1000;
      else if (per_valid && per_ready) seq_next <= seq_next + 1;
   end
   always @(negedge clk) begin
      per_valid <= src_on && (($urandom % 4) != 0);
      per_data  <= seq_next;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic poke(input int a, input logic [DW-1:0] v);
      @(negedge clk);
      pl_we = 1'b1; pl_addr = AW'(a); pl_data = v;
      @(negedge clk);
      pl_we = 1'b0;
   endtask

   task automatic put_desc(input int a, input int link, input int cnt,
                           input int stride, input int base);
      poke(a,     DW'(link));
      poke(a + 1, DW'(cnt));
      poke(a + 2, DW'(stride));
      poke(a + 3, DW'(base));
   endtask

   task automatic cfg_write(input bit en, input int link);
      @(negedge clk);
      cfg_we = 1'b1; cfg_en = en; cfg_link = AW'(link);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // expected memory image after walking the chain (R2, R3, R4, R7)
   function automatic int model_chain(input int cp0, input logic [DW-1:0] seq0);
      int cp = cp0;
      int n = 0;
      logic [DW-1:0] s = seq0;
      for (int i = 0; i < MEMW; i++) expm[i] = mem[i];
      for (int g = 0; g < 16 && cp != 0; g++) begin
         int c = int'(mem[cp + 1]);
         int st = int'($signed(mem[cp + 2]));
         int ix = int'(mem[cp + 3][AW-1:0]);
         for (int k = 0; k < c; k++) begin
            expm[ix] = s;
            s++;
            n++;
            ix = (ix + st) & (MEMW - 1);
         end
         cp = int'(mem[cp][AW-1:0]);
      end
      return n;
   endfunction

   task automatic wait_done(input string req, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 3000 && !seen; i++) begin
         @(negedge clk);
         if (chain_done) seen = 1'b1;
      end
      check(seen, req, "chain_done seen", seen, 1);
      if (seen) begin
         @(negedge clk);
         check(!chain_done, "R5", "chain_done one cycle", chain_done, 0);
      end
   endtask

   task automatic run_chain(input int cp, input string req);
      int n, bad;
      logic [DW-1:0] s0;
      bit seen;
      s0 = seq_next;
      n = model_chain(cp, s0);
      cfg_write(1'b1, cp);
      wait_done(req, seen);
      bad = 0;
      for (int i = 0; i < BUF_TOP; i++) if (mem[i] !== expm[i]) bad++;
      check(bad == 0, "R3", "memory image mismatches", bad, 0);
      check(seq_next - s0 == DW'(n), "R4", "words accepted",
            seq_next - s0, n);
   endtask

   // watchdog
   initial begin
      #600000;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      bit seen;
      int quiet;
      logic [DW-1:0] s0;
      void'($urandom(32'h5eed));
      for (int i = 0; i < MEMW; i++) mem[i] = 32'hDEAD0000 | DW'(i);
      repeat (4) @(negedge clk);
      // R11: reset state
      check(!chan_active && !per_ready && !mem_en && !chain_done, "R11",
            "reset outputs", {chan_active, per_ready, mem_en, chain_done}, 0);
      rst_n = 1'b1;
      src_on = 1'b1;

      // R1, R6: four consecutive reads, channel inactive while loading
      put_desc('hC0, 0, 3, 1, 'h10);
      s0 = seq_next;
      void'(model_chain('hC0, s0));
      @(negedge clk);
      cfg_we = 1'b1; cfg_en = 1'b1; cfg_link = AW'('hC0);
      @(negedge clk);
      cfg_we = 1'b0;
      for (int k = 0; k < 4; k++) begin
         check(mem_en && !mem_we && mem_addr == AW'('hC0 + k), "R1",
               "descriptor read address", mem_addr, 'hC0 + k);
         check(!chan_active && !per_ready, "R6", "inactive during load",
               {chan_active, per_ready}, 0);
         @(negedge clk);
      end
      wait_done("R5", seen);
      begin
         int bad = 0;
         for (int i = 0; i < BUF_TOP; i++) if (mem[i] !== expm[i]) bad++;
         check(bad == 0, "R2", "single descriptor image", bad, 0);
         check(seq_next - s0 == 3, "R3", "single descriptor words",
               seq_next - s0, 3);
      end

      // R4, R7: three-link chain with a zero-count middle and negative stride
      put_desc('hC0, 'hC4, 2, 3, 'h30);
      put_desc('hC4, 'hC8, 0, 1, 'h70);
      put_desc('hC8, 0, 3, -1, 'h50);
      run_chain('hC0, "R4");
      check(mem['h70] == (32'hDEAD0000 | 32'h70), "R7",
            "zero-count buffer untouched", mem['h70], 32'hDEAD0070);

      // R8: zero pointer with enable set performs no access
      cfg_write(1'b1, 0);
      quiet = 0;
      repeat (12) begin
         @(negedge clk);
         if (mem_en) quiet++;
      end
      check(quiet == 0, "R8", "accesses after zero pointer", quiet, 0);

      // constrained random chains
      for (int t = 0; t < 24; t++) begin
         int nd = 1 + ($urandom % 4);
         for (int d = 0; d < nd; d++) begin
            int strides[5] = '{1, 2, 3, -1, -2};
            int a = 'hC0 + 4 * d;
            int lk = (d == nd - 1) ? 0 : a + 4;
            put_desc(a, lk, $urandom % 7, strides[$urandom % 5],
                     'h20 + ($urandom % 'h70));
         end
         run_chain('hC0, "R5");
      end

      // R9, R10: ring of two descriptors, stopped by clearing enable
      put_desc('hE0, 'hE4, 4, 1, 'h10);
      put_desc('hE4, 'hE0, 4, 1, 'h18);
      s0 = seq_next;
      cfg_write(1'b1, 'hE0);
      repeat (90) @(negedge clk);
      while (!chan_active) @(negedge clk);
      check(seq_next - s0 > 8, "R10", "ring passes beyond one lap",
            seq_next - s0, 9);
      cfg_we = 1'b1; cfg_en = 1'b0; cfg_link = '0;
      @(negedge clk);
      cfg_we = 1'b0;
      check(!per_ready, "R9", "ready drops after disable", per_ready, 0);
      s0 = seq_next;
      quiet = 0;
      repeat (30) begin
         @(negedge clk);
         if (mem_en || per_ready || chan_active || chain_done) quiet++;
      end
      check(quiet == 0, "R9", "activity after disable", quiet, 0);
      check(seq_next == s0, "R9", "words after disable", seq_next - s0, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule